// File: doc/BRIEF.md
# Shared Dual-Port Mailbox with Doorbells

This block is a small register file shared by two agents: a host port and a responder port. Both ports see the same eight 64-bit message registers and the same two 64-bit doorbell registers. One side fills the message registers and rings the other side's doorbell. The rung side then reads the message, writes its reply into the message registers and rings the first side's doorbell in return.

Each doorbell answers at three offsets. One offset writes the value directly. One offset ANDs the write data into the current value, which clears the chosen bits. One offset ORs the write data into the current value, which sets the chosen bits. Because the AND and OR offsets exist, either side can clear or set a single bit in one write, with no read-modify-write. The most significant bit of the responder doorbell is brought out as the responder's message-available interrupt. The most significant bit of the host doorbell is brought out as the host's response-waiting interrupt.

Both ports use the same synchronous interface: an access strobe, a write enable, an address, write data, registered read data and an error flag.

Top module: `shared_mailbox`

## Requirements
- R1: After reset, every message register and both doorbells read as zero, both interrupts are low and both error flags are low.
- R2: Offsets 0x50 through 0x57 select the eight 64-bit message registers. A value written through either port reads back unchanged through either port.
- R3: The responder doorbell answers at 0x60 (direct write), 0x61 (AND) and 0x62 (OR). The host doorbell answers at 0x63 (direct write), 0x64 (AND) and 0x65 (OR). A read of any of the three offsets of a doorbell returns that doorbell's current value.
- R4: A write to an AND offset leaves the doorbell holding its previous value ANDed with the write data.
- R5: A write to an OR offset leaves the doorbell holding its previous value ORed with the write data.
- R6: `resp_irq` always equals bit 63 of the responder doorbell, and `host_irq` always equals bit 63 of the host doorbell. Both change only in the cycle after a write.
- R7: Read data is registered. It appears in the cycle after the access and shows the register value from before any write made in that same access cycle. When a port makes no access, its read data holds its last value.
- R8: An access to any offset not listed in R2 or R3 changes no register. In the next cycle it returns zero read data and raises the error flag of that port for exactly that one cycle.
- R9: When both ports write the same doorbell in one cycle, through any of its offsets, only the owner's write takes effect. The responder owns the responder doorbell and the host owns the host doorbell.
- R10: When both ports write the same message register in one cycle, only the host's write takes effect.
- R11: When the two ports write different registers in the same cycle, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write enable, valid while host_en is high |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| host_err | output | 1 | Host unmapped-access flag, high for one cycle |
| resp_en | input | 1 | Responder access strobe |
| resp_we | input | 1 | Responder write enable, valid while resp_en is high |
| resp_addr | input | 8 | Responder register offset |
| resp_wdata | input | 64 | Responder write data |
| resp_rdata | output | 64 | Responder read data, registered |
| resp_err | output | 1 | Responder unmapped-access flag, high for one cycle |
| resp_irq | output | 1 | Message-available interrupt, from bit 63 of the responder doorbell |
| host_irq | output | 1 | Response-waiting interrupt, from bit 63 of the host doorbell |

## Verification
Two things can happen in the same cycle: both ports can write one register, and one port can read a register while the other port updates it.

Directed cycles cover the following cases:
- Both ports write the same doorbell through different offsets. The owner's result must be the one that survives.
- Both ports write the same message register.
- The two ports write different registers, and both writes must land.

Random traffic is then drawn from a small pool of addresses. The pool makes same-register collisions and read-during-write cases frequent. Each read is compared with a bench model that computes the pre-write value and applies the priority rules on its own.

// File: rtl/shmbx_pkg.sv
package shmbx_pkg;

    // Doorbell offset within its group of three; the encoding follows the offset order.
    typedef enum logic [1:0] {
        BELL_WRITE = 2'd0,
        BELL_CLEAR = 2'd1,
        BELL_SET   = 2'd2
    } bell_op_e;

    localparam int BELL_ALIASES = 3;

endpackage

// File: rtl/shmbx_decode.sv
module shmbx_decode
    import shmbx_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MSG_BASE  = 'h50,
    parameter int MSG_COUNT = 8,
    parameter int RB_BASE   = 'h60,
    parameter int HB_BASE   = 'h63,
    localparam int IDX_W    = (MSG_COUNT > 1) ? $clog2(MSG_COUNT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_msg,
    output logic [IDX_W-1:0]  msg_idx,
    output logic              hit_rb,
    output logic              hit_hb,
    output bell_op_e          op,
    output logic              unmapped
);

    always_comb begin
        hit_msg = 1'b0;
        msg_idx = '0;
        for (int i = 0; i < MSG_COUNT; i++) begin
            if (addr == ADDR_W'(MSG_BASE + i)) begin
                hit_msg = 1'b1;
                msg_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        hit_rb = 1'b0;
        hit_hb = 1'b0;
        op     = BELL_WRITE;
        for (int k = 0; k < BELL_ALIASES; k++) begin
            if (addr == ADDR_W'(RB_BASE + k)) begin
                hit_rb = 1'b1;
                op     = bell_op_e'(2'(k));
            end
            if (addr == ADDR_W'(HB_BASE + k)) begin
                hit_hb = 1'b1;
                op     = bell_op_e'(2'(k));
            end
        end
    end

    assign unmapped = !(hit_msg || hit_rb || hit_hb);

endmodule

// File: rtl/shmbx_bell.sv
module shmbx_bell
    import shmbx_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit OWNER_RESP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  bell_op_e          h_op,
    input  logic [DATA_W-1:0] h_data,
    input  logic              r_wr,
    input  bell_op_e          r_op,
    input  logic [DATA_W-1:0] r_data,
    output logic [DATA_W-1:0] value
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } bell_st_t;

    bell_st_t st_d, st_q;

    logic              own_wr, oth_wr;
    bell_op_e          own_op, oth_op;
    logic [DATA_W-1:0] own_data, oth_data;

    generate
        if (OWNER_RESP) begin : g_resp_owns
            assign own_wr   = r_wr;
            assign own_op   = r_op;
            assign own_data = r_data;
            assign oth_wr   = h_wr;
            assign oth_op   = h_op;
            assign oth_data = h_data;
        end else begin : g_host_owns
            assign own_wr   = h_wr;
            assign own_op   = h_op;
            assign own_data = h_data;
            assign oth_wr   = r_wr;
            assign oth_op   = r_op;
            assign oth_data = r_data;
        end
    endgenerate

    function automatic logic [DATA_W-1:0] merge(
        input logic [DATA_W-1:0] old,
        input bell_op_e          op,
        input logic [DATA_W-1:0] d
    );
        case (op)
            BELL_CLEAR: return old & d;
            BELL_SET:   return old | d;
            default:    return d;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (own_wr) begin
            st_d.val = merge(st_q.val, own_op, own_data);
        end else if (oth_wr) begin
            st_d.val = merge(st_q.val, oth_op, oth_data);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.val;

endmodule

// File: rtl/shmbx_msgfile.sv
module shmbx_msgfile #(
    parameter int DATA_W    = 64,
    parameter int MSG_COUNT = 8,
    localparam int IDX_W    = (MSG_COUNT > 1) ? $clog2(MSG_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_data,
    input  logic              r_wr,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_data,
    output logic [DATA_W-1:0] regs_o [MSG_COUNT]
);

    logic [DATA_W-1:0] regs_d [MSG_COUNT];
    logic [DATA_W-1:0] regs_q [MSG_COUNT];

    generate
        for (genvar g = 0; g < MSG_COUNT; g++) begin : g_entry
            always_comb begin
                regs_d[g] = regs_q[g];
                if (h_wr && (h_idx == IDX_W'(g))) begin
                    regs_d[g] = h_data;
                end else if (r_wr && (r_idx == IDX_W'(g))) begin
                    regs_d[g] = r_data;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else begin
                    regs_q[g] <= regs_d[g];
                end
            end

            assign regs_o[g] = regs_q[g];
        end
    endgenerate

endmodule

// File: rtl/shared_mailbox.sv
module shared_mailbox
    import shmbx_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 8,
    parameter int MSG_BASE  = 'h50,
    parameter int MSG_COUNT = 8,
    parameter int RB_BASE   = 'h60,
    parameter int HB_BASE   = 'h63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_err,
    input  logic              resp_en,
    input  logic              resp_we,
    input  logic [ADDR_W-1:0] resp_addr,
    input  logic [DATA_W-1:0] resp_wdata,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_err,
    output logic              resp_irq,
    output logic              host_irq
);

    localparam int IDX_W  = (MSG_COUNT > 1) ? $clog2(MSG_COUNT) : 1;
    localparam int IRQ_BIT = DATA_W - 1;
    localparam int NPORT  = 2;   // index 0: host, index 1: responder

    typedef struct packed {
        logic [DATA_W-1:0] h_rdata;
        logic              h_err;
        logic [DATA_W-1:0] r_rdata;
        logic              r_err;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [ADDR_W-1:0] p_addr     [NPORT];
    logic              p_hit_msg  [NPORT];
    logic [IDX_W-1:0]  p_idx      [NPORT];
    logic              p_hit_rb   [NPORT];
    logic              p_hit_hb   [NPORT];
    bell_op_e          p_op       [NPORT];
    logic              p_unmapped [NPORT];

    assign p_addr[0] = host_addr;
    assign p_addr[1] = resp_addr;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_dec
            shmbx_decode #(
                .ADDR_W   (ADDR_W),
                .MSG_BASE (MSG_BASE),
                .MSG_COUNT(MSG_COUNT),
                .RB_BASE  (RB_BASE),
                .HB_BASE  (HB_BASE)
            ) u_dec (
                .addr    (p_addr[p]),
                .hit_msg (p_hit_msg[p]),
                .msg_idx (p_idx[p]),
                .hit_rb  (p_hit_rb[p]),
                .hit_hb  (p_hit_hb[p]),
                .op      (p_op[p]),
                .unmapped(p_unmapped[p])
            );
        end
    endgenerate

    logic h_wr, r_wr;
    assign h_wr = host_en && host_we && !p_unmapped[0];
    assign r_wr = resp_en && resp_we && !p_unmapped[1];

    logic [DATA_W-1:0] msg_vals [MSG_COUNT];
    logic [DATA_W-1:0] rb_val, hb_val;

    shmbx_msgfile #(
        .DATA_W   (DATA_W),
        .MSG_COUNT(MSG_COUNT)
    ) u_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .h_wr  (h_wr && p_hit_msg[0]),
        .h_idx (p_idx[0]),
        .h_data(host_wdata),
        .r_wr  (r_wr && p_hit_msg[1]),
        .r_idx (p_idx[1]),
        .r_data(resp_wdata),
        .regs_o(msg_vals)
    );

    shmbx_bell #(
        .DATA_W    (DATA_W),
        .OWNER_RESP(1'b1)
    ) u_resp_bell (
        .clk   (clk),
        .rst_n (rst_n),
        .h_wr  (h_wr && p_hit_rb[0]),
        .h_op  (p_op[0]),
        .h_data(host_wdata),
        .r_wr  (r_wr && p_hit_rb[1]),
        .r_op  (p_op[1]),
        .r_data(resp_wdata),
        .value (rb_val)
    );

    shmbx_bell #(
        .DATA_W    (DATA_W),
        .OWNER_RESP(1'b0)
    ) u_host_bell (
        .clk   (clk),
        .rst_n (rst_n),
        .h_wr  (h_wr && p_hit_hb[0]),
        .h_op  (p_op[0]),
        .h_data(host_wdata),
        .r_wr  (r_wr && p_hit_hb[1]),
        .r_op  (p_op[1]),
        .r_data(resp_wdata),
        .value (hb_val)
    );

    function automatic logic [DATA_W-1:0] pick(
        input logic             hm,
        input logic [IDX_W-1:0] ix,
        input logic             hr,
        input logic             hh
    );
        if (hm) return msg_vals[ix];
        if (hr) return rb_val;
        if (hh) return hb_val;
        return '0;
    endfunction

    always_comb begin
        st_d = st_q;
        if (host_en) begin
            st_d.h_rdata = pick(p_hit_msg[0], p_idx[0], p_hit_rb[0], p_hit_hb[0]);
        end
        if (resp_en) begin
            st_d.r_rdata = pick(p_hit_msg[1], p_idx[1], p_hit_rb[1], p_hit_hb[1]);
        end
        st_d.h_err = host_en && p_unmapped[0];
        st_d.r_err = resp_en && p_unmapped[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.h_rdata;
    assign host_err   = st_q.h_err;
    assign resp_rdata = st_q.r_rdata;
    assign resp_err   = st_q.r_err;
    assign resp_irq   = rb_val[IRQ_BIT];
    assign host_irq   = hb_val[IRQ_BIT];

endmodule

// File: rtl/shmbx_chk.sv
module shmbx_chk #(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 8,
    parameter int MSG_BASE  = 'h50,
    parameter int MSG_COUNT = 8,
    parameter int RB_BASE   = 'h60,
    parameter int HB_BASE   = 'h63
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_en,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_msb,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_err,
    input logic              resp_en,
    input logic              resp_we,
    input logic [ADDR_W-1:0] resp_addr,
    input logic              resp_msb,
    input logic [DATA_W-1:0] resp_rdata,
    input logic              resp_err,
    input logic              resp_irq,
    input logic              host_irq
);

    function automatic logic is_unmapped(input logic [ADDR_W-1:0] a);
        int unsigned v;
        v = int'(a);
        if (v >= MSG_BASE && v < MSG_BASE + MSG_COUNT) return 1'b0;
        if (v >= RB_BASE && v < RB_BASE + 3) return 1'b0;
        if (v >= HB_BASE && v < HB_BASE + 3) return 1'b0;
        return 1'b1;
    endfunction

    // R8
    host_unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && is_unmapped(host_addr) |=> host_err && (host_rdata == '0));

    // R8
    resp_unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_en && is_unmapped(resp_addr) |=> resp_err && (resp_rdata == '0));

    // R8
    no_access_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en && !resp_en |=> !host_err && !resp_err);

    // R6
    idle_irq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_en && host_we) && !(resp_en && resp_we) |=> $stable(resp_irq) && $stable(host_irq));

    // R9
    host_owns_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_en && host_we && (host_addr == ADDR_W'(HB_BASE + 2)) && host_msb |=> host_irq);

    // R9
    resp_owns_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_en && resp_we && (resp_addr == ADDR_W'(RB_BASE + 1)) && !resp_msb |=> !resp_irq);

endmodule

bind shared_mailbox shmbx_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MSG_BASE (MSG_BASE),
    .MSG_COUNT(MSG_COUNT),
    .RB_BASE  (RB_BASE),
    .HB_BASE  (HB_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_en   (host_en),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_msb  (host_wdata[DATA_W-1]),
    .host_rdata(host_rdata),
    .host_err  (host_err),
    .resp_en   (resp_en),
    .resp_we   (resp_we),
    .resp_addr (resp_addr),
    .resp_msb  (resp_wdata[DATA_W-1]),
    .resp_rdata(resp_rdata),
    .resp_err  (resp_err),
    .resp_irq  (resp_irq),
    .host_irq  (host_irq)
);

// File: tb/test_shared_mailbox.sv
module test_shared_mailbox;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_en, host_we, resp_en, resp_we;
    logic [7:0]  host_addr, resp_addr;
    logic [63:0] host_wdata, resp_wdata, host_rdata, resp_rdata;
    logic        host_err, resp_err, resp_irq, host_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] m_msg [8];
    logic [63:0] m_rb, m_hb;
    logic [63:0] exp_hr, exp_rr;
    logic        exp_he, exp_re;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_mailbox i_shared_mailbox (
        .clk(clk), .rst_n(rst_n),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_err(host_err),
        .resp_en(resp_en), .resp_we(resp_we), .resp_addr(resp_addr),
        .resp_wdata(resp_wdata), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .resp_irq(resp_irq), .host_irq(host_irq)
    );

    function automatic int reg_id(input logic [7:0] a);
        if (a >= 8'h50 && a <= 8'h57) return int'(a - 8'h50);
        if (a >= 8'h60 && a <= 8'h62) return 8;
        if (a >= 8'h63 && a <= 8'h65) return 9;
        return -1;
    endfunction

    function automatic logic [63:0] m_read(input logic [7:0] a);
        int id;
        id = reg_id(a);
        if (id < 0) return 64'd0;
        if (id < 8) return m_msg[id];
        if (id == 8) return m_rb;
        return m_hb;
    endfunction

    function automatic logic [63:0] bell_op(input logic [63:0] old, input int op, input logic [63:0] d);
        if (op == 1) return old & d;
        if (op == 2) return old | d;
        return d;
    endfunction

    task automatic m_write(input logic [7:0] a, input logic [63:0] d);
        int id;
        id = reg_id(a);
        if (id >= 0 && id < 8) m_msg[id] = d;
        else if (id == 8) m_rb = bell_op(m_rb, int'(a - 8'h60), d);
        else if (id == 9) m_hb = bell_op(m_hb, int'(a - 8'h63), d);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic hen, input logic hwe, input logic [7:0] ha, input logic [63:0] hd,
                         input logic ren, input logic rwe, input logic [7:0] ra, input logic [63:0] rd,
                         input string tag);
        int  hid, rid;
        bit  hw, rw;
        host_en = hen; host_we = hwe; host_addr = ha; host_wdata = hd;
        resp_en = ren; resp_we = rwe; resp_addr = ra; resp_wdata = rd;
        hid = reg_id(ha);
        rid = reg_id(ra);
        if (hen) exp_hr = m_read(ha);
        if (ren) exp_rr = m_read(ra);
        exp_he = hen && (hid < 0);
        exp_re = ren && (rid < 0);
        hw = hen && hwe && (hid >= 0);
        rw = ren && rwe && (rid >= 0);
        if (hw && rw && hid == rid) begin
            if (hid == 8) m_write(ra, rd);
            else          m_write(ha, hd);
        end else begin
            if (hw) m_write(ha, hd);
            if (rw) m_write(ra, rd);
        end
        @(negedge clk);
        chk({tag, " host rdata"}, host_rdata, exp_hr);
        chk({tag, " resp rdata"}, resp_rdata, exp_rr);
        chk({tag, " host err"}, 64'(host_err), 64'(exp_he));
        chk({tag, " resp err"}, 64'(resp_err), 64'(exp_re));
        chk("R6 resp_irq", 64'(resp_irq), 64'(m_rb[63]));
        chk("R6 host_irq", 64'(host_irq), 64'(m_hb[63]));
    endtask

    task automatic idle(input string tag);
        cycle(0, 0, 8'h00, 64'd0, 0, 0, 8'h00, 64'd0, tag);
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 20)
            0:  return 8'h00;
            1:  return 8'h58;
            2:  return 8'h66;
            3:  return 8'hFF;
            4:  return 8'h4F;
            5:  return 8'h5F;
            default: begin
                if ((r % 20) < 14) return 8'h50 + 8'((r % 20) - 6);
                return 8'h60 + 8'((r % 20) - 14);
            end
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) m_msg[i] = '0;
        m_rb = '0; m_hb = '0;
        exp_hr = '0; exp_rr = '0; exp_he = 0; exp_re = 0;
        rst_n = 1'b0;
        host_en = 0; host_we = 0; host_addr = '0; host_wdata = '0;
        resp_en = 0; resp_we = 0; resp_addr = '0; resp_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 host rdata", host_rdata, 64'd0);
        chk("R1 resp rdata", resp_rdata, 64'd0);
        chk("R1 irqs", {62'd0, resp_irq, host_irq}, 64'd0);
        chk("R1 errs", {62'd0, resp_err, host_err}, 64'd0);
        cycle(1, 0, 8'h50, 0, 1, 0, 8'h63, 0, "R1 read after reset");

        // R2 message register shared between ports
        cycle(1, 1, 8'h53, 64'hDEAD_BEEF_0123_4567, 0, 0, 0, 0, "R2 host write");
        cycle(0, 0, 0, 0, 1, 0, 8'h53, 0, "R2 resp read");

        // R3 direct write, reads through all aliases
        cycle(0, 0, 0, 0, 1, 1, 8'h63, 64'h8000_0000_0000_00A5, "R3 resp rings host");
        cycle(1, 0, 8'h64, 0, 1, 0, 8'h65, 0, "R3 alias reads");

        // R4 AND clears the interrupt bit
        cycle(1, 1, 8'h64, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "R4 host clears");
        cycle(1, 0, 8'h63, 0, 0, 0, 0, 0, "R4 readback");

        // R5 OR sets the responder interrupt
        cycle(1, 1, 8'h62, 64'h8000_0000_0000_0000, 0, 0, 0, 0, "R5 host rings resp");
        cycle(0, 0, 0, 0, 1, 0, 8'h61, 0, "R5 readback");

        // R9 doorbell collisions: owner wins
        cycle(1, 1, 8'h60, 64'd0, 1, 1, 8'h62, 64'h1, "R9 resp bell collision");
        cycle(1, 1, 8'h63, 64'h8000_0000_0000_000F, 1, 1, 8'h64, 64'd0, "R9 host bell collision");
        cycle(1, 0, 8'h60, 0, 1, 0, 8'h63, 0, "R9 readback");

        // R10 message collision: host wins
        cycle(1, 1, 8'h55, 64'h1111, 1, 1, 8'h55, 64'h2222, "R10 msg collision");
        cycle(0, 0, 0, 0, 1, 0, 8'h55, 0, "R10 readback");

        // R11 distinct targets both land
        cycle(1, 1, 8'h50, 64'hAAAA, 1, 1, 8'h57, 64'hBBBB, "R11 both write");
        cycle(1, 0, 8'h57, 0, 1, 0, 8'h50, 0, "R11 readback");

        // R7 read during write returns old value; idle holds
        cycle(1, 1, 8'h51, 64'h0A0A, 0, 0, 0, 0, "R7 first write");
        cycle(1, 1, 8'h51, 64'h0B0B, 0, 0, 0, 0, "R7 old value");
        idle("R7 hold");

        // R8 unmapped access: zero data, one-cycle error, no change
        cycle(1, 0, 8'h58, 0, 1, 1, 8'h66, 64'hFFFF_FFFF_FFFF_FFFF, "R8 unmapped");
        idle("R8 error drops");
        cycle(1, 0, 8'h60, 0, 1, 0, 8'h63, 0, "R8 bells untouched");

        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ha, ra;
            string tg;
            ha = pick_addr($urandom);
            ra = pick_addr($urandom);
            tg = (reg_id(ha) < 0) ? "R8 random" : ((reg_id(ha) < 8) ? "R2 random" : "R3 random");
            cycle(1'($urandom), 1'($urandom), ha, {$urandom, $urandom},
                  1'($urandom), 1'($urandom), ra, {$urandom, $urandom}, tg);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule